// File: doc/BRIEF.md
# Decode-Stage Instruction Prefix Expander

This block sits in the decode stage of a RISC-V-style core and watches the stream of accepted instructions, one per `in_valid` cycle. It treats one reserved pattern in the compressed opcode space as a prefix parcel. A prefix parcel produces no instruction output. Its 11-bit payload is held as hidden decode state and attached to the next instruction only. From that state the block widens each register operand to a 7-bit index into a 128-entry file and supplies a vector/predication mode. Two prefixes in a row are not stacked. The pair is reported as a separate operation class on its own output.

The pending state (a flag and the payload) is visible at all times on the save port, so trap entry can store it when a trap lands between a prefix and its target. A flush discards the pending prefix. A flush that has the restore input high in the same cycle loads saved state instead and re-arms the prefix. When the pending state changes, the block pulses a redecode strobe so that instructions already partly decoded with the old state can be decoded again. All instruction outputs are registered and appear one cycle after the accepting edge.

Top module: `pfx_expander`

## Requirements
- R1: With `en` high, an accepted parcel whose bits [15:13] are 3'b100 and bits [1:0] are 2'b00 is captured as a prefix. Its payload is bits [12:2]. It produces no output, and `save_pending` reads 1 with `save_payload` equal to the payload.
- R2: The next accepted non-prefix instruction is output one cycle after its accepting edge with `out_prefixed`=1, and the pending state is cleared. The instruction after it is output with `out_prefixed`=0.
- R3: A compressed instruction (bits [1:0] not 2'b11) takes rd and rs1 from bits [9:7] and rs2 from bits [4:2]. Each is output as {bank, field, 2'b00} when prefixed and as {4'b0001, field} when not. The banks are payload bits [3:2] for rd, [5:4] for rs1 and [7:6] for rs2.
- R4: A 32-bit instruction takes rd from [11:7], rs1 from [19:15] and rs2 from [24:20]. Each is output as {bank, field} when prefixed and as {2'b00, field} when not.
- R5: `out_mode` equals payload bits [1:0] for a prefixed instruction: 00 scalar, 01 vector unpredicated, 10 vector predicated by source 0, 11 vector predicated by source 1. It is 00 for any other output.
- R6: A prefix accepted while a prefix is pending gives one output with `out_double`=1 and `out_prefixed`=0, and clears the pending state.
- R7: With `en` low, a prefix-pattern parcel is output as an ordinary compressed instruction and no state is captured.
- R8: `flush` together with `restore` loads `restore_pending`/`restore_payload` into the pending state, and a following instruction is expanded with it.
- R9: `flush` without `restore` clears the pending state. An instruction offered in a flush cycle produces no output.
- R10: `redecode` is high in the cycle after any edge at which the pending flag changed, or at which the payload changed while a prefix stays pending. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Enables prefix recognition |
| in_valid | input | 1 | An instruction is accepted this cycle |
| in_instr | input | 32 | Instruction bits; compressed parcels use [15:0] |
| flush | input | 1 | Pipeline flush |
| restore | input | 1 | Load saved prefix state with the flush |
| restore_pending | input | 1 | Saved pending flag |
| restore_payload | input | 11 | Saved payload |
| save_pending | output | 1 | Current pending flag |
| save_payload | output | 11 | Current payload |
| out_valid | output | 1 | Output instruction strobe |
| out_prefixed | output | 1 | Output instruction carries a prefix |
| out_double | output | 1 | Back-to-back prefix operation |
| out_mode | output | 2 | Vector/predication mode |
| out_rd | output | 7 | Extended destination index |
| out_rs1 | output | 7 | Extended source 1 index |
| out_rs2 | output | 7 | Extended source 2 index |
| redecode | output | 1 | Pending state changed; redecode younger work |

## Verification
The bench targets the one-shot lifetime of a prefix. A design that leaks the state would mark the instruction after the target as prefixed, and it would also miss the redecode pulse when the state clears. Back-to-back prefixes are applied to catch a design that stacks them or overwrites the payload instead of raising `out_double`. Flush with and without restore is exercised. A design that ignores restore loses the re-armed banks, and one that lets a flushed instruction through emits a spurious output. Widening is checked in both formats with all four modes and unequal banks per field, so swapped bank slices or a missing alignment shift show up directly in the indices.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
    localparam int PAY_W   = 11;
    localparam int BANK_W  = 2;
    localparam int CREG_W  = 3;
    localparam int XREG_W  = 5;
    localparam int MODE_W  = 2;
    localparam int NFIELD  = 3;
    localparam int REG_W   = BANK_W + XREG_W;
    localparam int ALIGN_W = REG_W - BANK_W - CREG_W;

    typedef struct packed {
        logic             pend;
        logic [PAY_W-1:0] pay;
    } pfx_state_t;

    typedef struct packed {
        logic                         vld;
        logic                         pfx;
        logic                         dbl;
        logic [MODE_W-1:0]            mode;
        logic [NFIELD-1:0][REG_W-1:0] idx;
        logic                         redec;
    } pfx_out_t;
endpackage

// File: rtl/pfx_match.sv
module pfx_match
    import pfx_pkg::*;
(
    input  logic [15:0]      parcel,
    input  logic             en,
    output logic             is_comp,
    output logic             is_pfx,
    output logic [PAY_W-1:0] payload
);
    always_comb begin
        is_comp = (parcel[1:0] != 2'b11);
        is_pfx  = en && (parcel[15:13] == 3'b100) && (parcel[1:0] == 2'b00);
        payload = parcel[2 +: PAY_W];
    end
endmodule

// File: rtl/pfx_regext.sv
module pfx_regext
    import pfx_pkg::*;
#(
    parameter int FIELD = 0
) (
    input  logic [31:0]       instr,
    input  logic              is_comp,
    input  logic              prefixed,
    input  logic [BANK_W-1:0] bank,
    output logic [REG_W-1:0]  idx
);
    localparam int C_LSB = (FIELD == 2) ? 2 : 7;
    localparam int X_LSB = (FIELD == 0) ? 7 : ((FIELD == 1) ? 15 : 20);

    logic [CREG_W-1:0] c_fld;
    logic [XREG_W-1:0] x_fld;

    always_comb begin
        c_fld = instr[C_LSB +: CREG_W];
        x_fld = instr[X_LSB +: XREG_W];
        if (is_comp) begin
            if (prefixed) idx = {bank, c_fld, {ALIGN_W{1'b0}}};
            else          idx = {{(REG_W-CREG_W-1){1'b0}}, 1'b1, c_fld};
        end else begin
            if (prefixed) idx = {bank, x_fld};
            else          idx = {{BANK_W{1'b0}}, x_fld};
        end
    end
endmodule

// File: rtl/pfx_expander.sv
module pfx_expander
    import pfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              in_valid,
    input  logic [31:0]       in_instr,
    input  logic              flush,
    input  logic              restore,
    input  logic              restore_pending,
    input  logic [PAY_W-1:0]  restore_payload,
    output logic              save_pending,
    output logic [PAY_W-1:0]  save_payload,
    output logic              out_valid,
    output logic              out_prefixed,
    output logic              out_double,
    output logic [MODE_W-1:0] out_mode,
    output logic [REG_W-1:0]  out_rd,
    output logic [REG_W-1:0]  out_rs1,
    output logic [REG_W-1:0]  out_rs2,
    output logic              redecode
);
    pfx_state_t st_d, st_q;
    pfx_out_t   o_d, o_q;

    logic                         is_comp, is_pfx;
    logic [PAY_W-1:0]             payload;
    logic [NFIELD-1:0][REG_W-1:0] idx;

    pfx_match u_match (
        .parcel  (in_instr[15:0]),
        .en      (en),
        .is_comp (is_comp),
        .is_pfx  (is_pfx),
        .payload (payload)
    );

    for (genvar f = 0; f < NFIELD; f++) begin : g_field
        pfx_regext #(.FIELD(f)) u_ext (
            .instr    (in_instr),
            .is_comp  (is_comp),
            .prefixed (st_q.pend),
            .bank     (st_q.pay[MODE_W + BANK_W*f +: BANK_W]),
            .idx      (idx[f])
        );
    end

    always_comb begin
        st_d = st_q;
        o_d  = '0;
        if (flush) begin
            st_d.pend = restore && restore_pending;
            st_d.pay  = restore ? restore_payload : st_q.pay;
        end else if (in_valid) begin
            if (is_pfx && st_q.pend) begin
                o_d.vld   = 1'b1;
                o_d.dbl   = 1'b1;
                st_d.pend = 1'b0;
            end else if (is_pfx) begin
                st_d.pend = 1'b1;
                st_d.pay  = payload;
            end else begin
                o_d.vld   = 1'b1;
                o_d.pfx   = st_q.pend;
                o_d.mode  = st_q.pend ? st_q.pay[MODE_W-1:0] : '0;
                o_d.idx   = idx;
                st_d.pend = 1'b0;
            end
        end
        o_d.redec = (st_d.pend != st_q.pend) ||
                    (st_d.pend && (st_d.pay != st_q.pay));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            o_q  <= '0;
        end else begin
            st_q <= st_d;
            o_q  <= o_d;
        end
    end

    assign save_pending = st_q.pend;
    assign save_payload = st_q.pay;
    assign out_valid    = o_q.vld;
    assign out_prefixed = o_q.pfx;
    assign out_double   = o_q.dbl;
    assign out_mode     = o_q.mode;
    assign out_rd       = o_q.idx[0];
    assign out_rs1      = o_q.idx[1];
    assign out_rs2      = o_q.idx[2];
    assign redecode     = o_q.redec;

    a_r6_double_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        out_double |-> (out_valid && !out_prefixed));

    a_r2_single_use: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_prefixed) |=> !(out_valid && out_prefixed));

    a_r5_scalar_default: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_prefixed) |-> (out_mode == '0));

    a_r7_disabled_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !en && !flush) |=> (out_valid && !out_double));

    a_r9_flush_drops: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);

    a_r8_restore_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && restore && restore_pending) |=> save_pending);
endmodule

// File: tb/test_pfx_expander.sv
module test_pfx_expander;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic        flush = 1'b0, restore = 1'b0, restore_pending = 1'b0;
    logic [10:0] restore_payload = '0;
    logic        save_pending, out_valid, out_prefixed, out_double, redecode;
    logic [10:0] save_payload;
    logic [1:0]  out_mode;
    logic [6:0]  out_rd, out_rs1, out_rs2;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pfx_expander i_pfx_expander (
        .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid), .in_instr(in_instr),
        .flush(flush), .restore(restore), .restore_pending(restore_pending),
        .restore_payload(restore_payload), .save_pending(save_pending),
        .save_payload(save_payload), .out_valid(out_valid), .out_prefixed(out_prefixed),
        .out_double(out_double), .out_mode(out_mode), .out_rd(out_rd), .out_rs1(out_rs1),
        .out_rs2(out_rs2), .redecode(redecode)
    );

    function automatic logic [15:0] mk_pfx(input logic [1:0] mode, brd, brs1, brs2);
        return {3'b100, 3'b000, brs2, brs1, brd, mode, 2'b00};
    endfunction
    function automatic logic [31:0] mk_c(input logic [2:0] ra, rb);
        return {16'h0, 3'b100, 3'b011, ra, 2'b11, rb, 2'b01};
    endfunction
    function automatic logic [31:0] mk_x(input logic [4:0] rd, rs1, rs2);
        return {7'b0, rs2, rs1, 3'b000, rd, 7'b0110011};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] ins, input logic fl,
                        input logic rs, input logic rp, input logic [10:0] rpay);
        @(negedge clk);
        in_valid = v; in_instr = ins; flush = fl;
        restore = rs; restore_pending = rp; restore_payload = rpay;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; flush = 1'b0; restore = 1'b0;
    endtask

    task automatic send(input logic [31:0] ins);
        step(1'b1, ins, 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic t_reset;
        chk("R1", "reset out_valid", out_valid, 0);
        chk("R1", "reset save_pending", save_pending, 0);
        chk("R10", "reset redecode", redecode, 0);
    endtask

    task automatic t_compressed;
        logic [15:0] p = mk_pfx(2'b10, 2'd3, 2'd1, 2'd2);
        send({16'h0, p});
        chk("R1", "capture out_valid", out_valid, 0);
        chk("R1", "capture save_pending", save_pending, 1);
        chk("R1", "capture save_payload", save_payload, p[12:2]);
        chk("R10", "capture redecode", redecode, 1);
        send(mk_c(3'd5, 3'd6));
        chk("R2", "target valid", out_valid, 1);
        chk("R2", "target prefixed", out_prefixed, 1);
        chk("R3", "c rd", out_rd, {2'd3, 3'd5, 2'b00});
        chk("R3", "c rs1", out_rs1, {2'd1, 3'd5, 2'b00});
        chk("R3", "c rs2", out_rs2, {2'd2, 3'd6, 2'b00});
        chk("R5", "c mode", out_mode, 2);
        chk("R10", "consume redecode", redecode, 1);
        chk("R2", "consumed save_pending", save_pending, 0);
        send(mk_c(3'd5, 3'd6));
        chk("R2", "after prefixed", out_prefixed, 0);
        chk("R3", "plain c rd", out_rd, {4'b0001, 3'd5});
        chk("R3", "plain c rs2", out_rs2, {4'b0001, 3'd6});
        chk("R5", "plain mode", out_mode, 0);
        chk("R10", "no change redecode", redecode, 0);
    endtask

    task automatic t_wide;
        send({16'h0, mk_pfx(2'b01, 2'd1, 2'd2, 2'd3)});
        send(mk_x(5'd7, 5'd20, 5'd31));
        chk("R4", "x rd", out_rd, {2'd1, 5'd7});
        chk("R4", "x rs1", out_rs1, {2'd2, 5'd20});
        chk("R4", "x rs2", out_rs2, {2'd3, 5'd31});
        chk("R5", "x mode", out_mode, 1);
        send(mk_x(5'd7, 5'd20, 5'd31));
        chk("R4", "plain x rd", out_rd, 7);
        chk("R4", "plain x rs2", out_rs2, 31);
        chk("R2", "plain x prefixed", out_prefixed, 0);
    endtask

    task automatic t_modes;
        for (int m = 0; m < 4; m++) begin
            send({16'h0, mk_pfx(2'(m), 2'd0, 2'd0, 2'd0)});
            send(mk_c(3'd1, 3'd2));
            chk("R5", "mode sweep", out_mode, m);
        end
    endtask

    task automatic t_double;
        send({16'h0, mk_pfx(2'b11, 2'd1, 2'd1, 2'd1)});
        send({16'h0, mk_pfx(2'b10, 2'd2, 2'd2, 2'd2)});
        chk("R6", "double valid", out_valid, 1);
        chk("R6", "double flag", out_double, 1);
        chk("R6", "double prefixed", out_prefixed, 0);
        chk("R6", "double clears", save_pending, 0);
        send(mk_c(3'd3, 3'd4));
        chk("R6", "after double prefixed", out_prefixed, 0);
        chk("R6", "after double flag", out_double, 0);
        chk("R6", "after double rd", out_rd, {4'b0001, 3'd3});
    endtask

    task automatic t_disabled;
        logic [15:0] p = mk_pfx(2'b01, 2'd2, 2'd3, 2'd1);
        en = 1'b0;
        send({16'h0, p});
        chk("R7", "disabled valid", out_valid, 1);
        chk("R7", "disabled prefixed", out_prefixed, 0);
        chk("R7", "disabled double", out_double, 0);
        chk("R7", "disabled rd", out_rd, {4'b0001, p[9:7]});
        chk("R7", "disabled no capture", save_pending, 0);
        en = 1'b1;
    endtask

    task automatic t_flush;
        send({16'h0, mk_pfx(2'b01, 2'd3, 2'd3, 2'd3)});
        step(1'b1, mk_c(3'd1, 3'd1), 1'b1, 1'b0, 1'b0, '0);
        chk("R9", "flush drops output", out_valid, 0);
        chk("R9", "flush clears", save_pending, 0);
        chk("R10", "flush redecode", redecode, 1);
        send(mk_c(3'd1, 3'd1));
        chk("R9", "after flush prefixed", out_prefixed, 0);
    endtask

    task automatic t_restore;
        logic [15:0] p = mk_pfx(2'b11, 2'd2, 2'd3, 2'd1);
        step(1'b1, mk_c(3'd1, 3'd1), 1'b1, 1'b1, 1'b1, p[12:2]);
        chk("R8", "restore no output", out_valid, 0);
        chk("R8", "restore pending", save_pending, 1);
        chk("R8", "restore payload", save_payload, p[12:2]);
        send(mk_c(3'd7, 3'd4));
        chk("R8", "restored prefixed", out_prefixed, 1);
        chk("R8", "restored rd", out_rd, {2'd2, 3'd7, 2'b00});
        chk("R8", "restored rs1", out_rs1, {2'd3, 3'd7, 2'b00});
        chk("R8", "restored rs2", out_rs2, {2'd1, 3'd4, 2'b00});
        chk("R8", "restored mode", out_mode, 3);
    endtask

    initial begin
        fork
            begin
                repeat (4) @(posedge clk);
                @(negedge clk) rst_n = 1'b1;
                t_reset();
                t_compressed();
                t_wide();
                t_modes();
                t_double();
                t_disabled();
                t_flush();
                t_restore();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule